// File: doc/BRIEF.md
# Host Buffer Data Port

This block is the host-side data window of a network controller's packet buffer. A single selected port address carries traffic in both directions. A host write stores data in a transmit FIFO. A host read takes data from a separate receive FIFO. Because each direction has its own FIFO, no bidirectional steering is needed, and writes and reads may interleave in any order. The FIFO pointers advance on their own.

Each FIFO stores bytes. Two configuration inputs are applied to every access as it happens. The first chooses between byte and word transfers. The second chooses which data lane carries the earlier byte of a word, so the port can serve both little-endian and big-endian hosts. The rest of the controller drains the transmit FIFO and fills the receive FIFO one byte at a time, and it sees the full and empty status of both FIFOs. Two sticky flags record a write that was dropped and a read that found too little data.

Top module: `hbp_port`

## Requirements
- R1: After synchronous reset, both FIFOs are empty and not full, both sticky flags are 0, and `host_rdata` is 0.
- R2: With `cfg_word`=0, a selected host write stores only `host_wdata[7:0]` as one FIFO entry. Bits 15:8 are ignored.
- R3: With `cfg_word`=1 and `cfg_swap`=0, a selected host write stores two entries: `host_wdata[7:0]` first, then `host_wdata[15:8]`.
- R4: With `cfg_word`=1 and `cfg_swap`=1, a selected host write stores `host_wdata[15:8]` first, then `host_wdata[7:0]`.
- R5: With `cfg_word`=0, a selected host read removes one receive entry and returns it as `{8'h00, entry}` on `host_rdata`. The value appears in the cycle after the read strobe and is held until the next read.
- R6: With `cfg_word`=1 and `cfg_swap`=0, a read removes two entries and returns the earlier one in bits 7:0 and the later one in bits 15:8.
- R7: With `cfg_word`=1 and `cfg_swap`=1, a read returns the earlier entry in bits 15:8 and the later one in bits 7:0.
- R8: A write that needs more free entries than the transmit FIFO has is dropped whole, with no partial word stored. It sets `tx_overflow`, which stays 1 until reset.
- R9: A read that needs more entries than the receive FIFO holds removes nothing and returns 0. It sets `rx_underflow`, which stays 1 until reset.
- R10: Each FIFO holds `DEPTH` bytes (8 by default). Full is 1 exactly at `DEPTH` entries and empty is 1 exactly at zero entries.
- R11: A write and a read in the same cycle both take effect, each on its own FIFO.
- R12: `host_wr` and `host_rd` have no effect while `host_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Port address decoded |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| cfg_word | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_swap | input | 1 | 1 = earlier byte on bits 15:8 |
| host_rdata | output | 16 | Registered host read data |
| tx_push | output | 1 | Host write accepted into the transmit FIFO |
| rx_pop | output | 1 | Host read took data from the receive FIFO |
| tx_pop | input | 1 | Controller takes one transmit byte |
| tx_data | output | 8 | Transmit FIFO head byte |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Controller stores one receive byte |
| rx_data | input | 8 | Receive byte from the controller |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_overflow | output | 1 | Sticky dropped-write flag |
| rx_underflow | output | 1 | Sticky short-read flag |

## Verification
The bench builds the port with the default `DEPTH` of 8. At that depth both FIFOs can be filled to the brim with a few accesses, which makes several boundary cases easy to reach. One is the exact full boundary. Another is a word write that arrives with only seven entries occupied and must be dropped whole. A third is a word read that finds a single byte waiting. All four lane and order combinations are used in both directions, and the same-cycle write and read case is included.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t first;
        byte_t second;
    } pair_t;

    typedef enum logic { XFER_BYTE = 1'b0, XFER_WORD = 1'b1 } xfer_e;
    typedef enum logic { ORDER_LOW_FIRST = 1'b0, ORDER_HIGH_FIRST = 1'b1 } order_e;

    function automatic pair_t split_word(input logic [15:0] w, input order_e o);
        pair_t p;
        if (o == ORDER_HIGH_FIRST) begin
            p.first  = w[15:8];
            p.second = w[7:0];
        end else begin
            p.first  = w[7:0];
            p.second = w[15:8];
        end
        return p;
    endfunction

    function automatic logic [15:0] join_word(input pair_t p, input order_e o);
        return (o == ORDER_HIGH_FIRST) ? {p.first, p.second} : {p.second, p.first};
    endfunction

endpackage

// File: rtl/hbp_fifo.sv
module hbp_fifo
    import hbp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  pair_t         push_pair,
    input  logic [1:0]    pop_n,
    output pair_t         head,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    byte_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] free_c;
    logic          push_ok, pop_ok;

    assign free_c  = DEPTH_C - count;
    assign push_ok = (CW'(push_n) <= free_c);
    assign pop_ok  = (CW'(pop_n) <= count);

    assign head.first  = mem[rptr];
    assign head.second = mem[rptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (push_ok && push_n != 2'd0) begin
            mem[wptr] <= push_pair.first;
            if (push_n == 2'd2)
                mem[wptr + AW'(1)] <= push_pair.second;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(push_n);
            if (pop_ok)  rptr <= rptr + AW'(pop_n);
            count <= count + (push_ok ? CW'(push_n) : '0) - (pop_ok ? CW'(pop_n) : '0);
        end
    end

endmodule

// File: rtl/hbp_wr_path.sv
module hbp_wr_path
    import hbp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  xfer_e         mode,
    input  order_e        order,
    input  logic [15:0]   wdata,
    input  logic [CW-1:0] count,
    output logic [1:0]    push_n,
    output pair_t         push_pair,
    output logic          overflow
);
    localparam logic [NW-1:0] DEPTH_V = NW'(DEPTH);

    logic [NW-1:0] need;
    logic          accept;

    assign need   = (mode == XFER_WORD) ? NW'(2) : NW'(1);
    assign accept = req && (({1'b0, count} + need) <= DEPTH_V);
    assign push_n = accept ? need[1:0] : 2'd0;

    always_comb begin
        if (mode == XFER_WORD) begin
            push_pair = split_word(wdata, order);
        end else begin
            push_pair.first  = wdata[7:0];
            push_pair.second = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  overflow <= 1'b0;
        else if (req && !accept)  overflow <= 1'b1;
    end

endmodule

// File: rtl/hbp_rd_path.sv
module hbp_rd_path
    import hbp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  xfer_e         mode,
    input  order_e        order,
    input  pair_t         head,
    input  logic [CW-1:0] count,
    output logic [1:0]    pop_n,
    output logic [15:0]   rdata,
    output logic          underflow
);
    logic [CW-1:0] need;
    logic          accept;

    assign need   = (mode == XFER_WORD) ? CW'(2) : CW'(1);
    assign accept = req && (need <= count);
    assign pop_n  = accept ? need[1:0] : 2'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            underflow <= 1'b0;
        end else if (req) begin
            if (!accept) begin
                rdata     <= '0;
                underflow <= 1'b1;
            end else if (mode == XFER_WORD) begin
                rdata <= join_word(head, order);
            end else begin
                rdata <= {8'h00, head.first};
            end
        end
    end

endmodule

// File: rtl/hbp_port.sv
module hbp_port
    import hbp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    input  logic        cfg_word,
    input  logic        cfg_swap,
    output logic [15:0] host_rdata,
    output logic        tx_push,
    output logic        rx_pop,
    input  logic        tx_pop,
    output logic [7:0]  tx_data,
    output logic        tx_full,
    output logic        tx_empty,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    output logic        rx_full,
    output logic        rx_empty,
    output logic        tx_overflow,
    output logic        rx_underflow
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    xfer_e         mode;
    order_e        order;
    logic [1:0]    tx_push_n, rx_pop_n;
    pair_t         tx_in_pair, tx_head, rx_head, rx_in_pair;
    logic [CW-1:0] tx_count, rx_count;

    assign mode  = cfg_word ? XFER_WORD : XFER_BYTE;
    assign order = cfg_swap ? ORDER_HIGH_FIRST : ORDER_LOW_FIRST;

    hbp_wr_path #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst(rst), .req(host_sel && host_wr), .mode(mode), .order(order),
        .wdata(host_wdata), .count(tx_count), .push_n(tx_push_n),
        .push_pair(tx_in_pair), .overflow(tx_overflow)
    );

    hbp_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .push_n(tx_push_n), .push_pair(tx_in_pair),
        .pop_n({1'b0, tx_pop}), .head(tx_head), .count(tx_count)
    );

    assign rx_in_pair.first  = rx_data;
    assign rx_in_pair.second = '0;

    hbp_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .push_n({1'b0, rx_push}), .push_pair(rx_in_pair),
        .pop_n(rx_pop_n), .head(rx_head), .count(rx_count)
    );

    hbp_rd_path #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst(rst), .req(host_sel && host_rd), .mode(mode), .order(order),
        .head(rx_head), .count(rx_count), .pop_n(rx_pop_n),
        .rdata(host_rdata), .underflow(rx_underflow)
    );

    assign tx_push  = (tx_push_n != 2'd0);
    assign rx_pop   = (rx_pop_n != 2'd0);
    assign tx_data  = tx_head.first;
    assign tx_full  = (tx_count == DEPTH_C);
    assign tx_empty = (tx_count == '0);
    assign rx_full  = (rx_count == DEPTH_C);
    assign rx_empty = (rx_count == '0);

endmodule

// File: rtl/hbp_port_chk.sv
module hbp_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_sel,
    input logic        host_wr,
    input logic        host_rd,
    input logic        tx_push,
    input logic        rx_pop,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        rx_full,
    input logic        rx_empty,
    input logic        tx_overflow,
    input logic        rx_underflow,
    input logic [15:0] host_rdata
);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow);

    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |=> rx_underflow);

    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_rd && rx_empty) |=> (host_rdata == 16'h0000 && rx_underflow));

    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_push);

    a_r10_tx_status_excl: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty));

    a_r10_rx_status_excl: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    a_r12_unselected_quiet: assert property (@(posedge clk) disable iff (rst)
        !host_sel |-> (!tx_push && !rx_pop));

    a_r12_strobe_needed: assert property (@(posedge clk) disable iff (rst)
        (tx_push |-> host_wr) and (rx_pop |-> host_rd));
endmodule

bind hbp_port hbp_port_chk u_chk (.*);

// File: tb/hbp_port_test.sv
module hbp_port_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 0, host_wr = 0, host_rd = 0;
    logic [15:0] host_wdata = '0;
    logic        cfg_word = 0, cfg_swap = 0;
    logic [15:0] host_rdata;
    logic        tx_push, rx_pop;
    logic        tx_pop = 0;
    logic [7:0]  tx_data;
    logic        tx_full, tx_empty;
    logic        rx_push = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_full, rx_empty, tx_overflow, rx_underflow;

    int vectors = 0;
    int errors  = 0;
    int tx_cnt  = 0;
    logic [7:0] txq [$];

    always #(PERIOD/2) clk = ~clk;

    hbp_port #(.DEPTH(DEPTH)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every tx byte taken by the controller must match the queue
    always @(negedge clk) begin
        #1;
        if (tx_pop) begin
            if (txq.size() == 0) begin
                vectors++; errors++;
                $display("FAIL R2/R3/R4 tx: actual %h expected none", tx_data);
            end else begin
                check("R2/R3/R4 tx order", {24'h0, tx_data}, {24'h0, txq.pop_front()});
            end
        end
    end

    // Driver: one host access; write expectations go to the scoreboard queue
    task automatic host_op(input logic sel, input logic wr, input logic rd, input logic [15:0] wd);
        int need;
        need = cfg_word ? 2 : 1;
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        if (sel && wr && (tx_cnt + need <= DEPTH)) begin
            tx_cnt += need;
            if (!cfg_word) txq.push_back(wd[7:0]);
            else if (cfg_swap) begin txq.push_back(wd[15:8]); txq.push_back(wd[7:0]); end
            else begin txq.push_back(wd[7:0]); txq.push_back(wd[15:8]); end
        end
        @(negedge clk);
        host_sel = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_pop = 1;
            @(negedge clk); tx_pop = 0;
            tx_cnt--;
        end
    endtask

    task automatic rx_fill(input logic [7:0] b);
        @(negedge clk); rx_push = 1; rx_data = b;
        @(negedge clk); rx_push = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 tx_empty", tx_empty, 1); check("R1 rx_empty", rx_empty, 1);
        check("R1 tx_full", tx_full, 0);   check("R1 rx_full", rx_full, 0);
        check("R1 flags", {tx_overflow, rx_underflow}, 0);
        check("R1 rdata", host_rdata, 0);

        // R2 byte write, upper lane ignored
        cfg_word = 0; host_op(1, 1, 0, 16'hA55A); drain(1);
        // R3 word write, low lane first
        cfg_word = 1; cfg_swap = 0; host_op(1, 1, 0, 16'h1234); drain(2);
        // R4 word write, high lane first
        cfg_swap = 1; host_op(1, 1, 0, 16'h1234); drain(2);
        check("R2/R3/R4 queue drained", txq.size(), 0);

        // R12 unselected write and read have no effect
        host_op(0, 1, 0, 16'hFFFF);
        check("R12 tx stays empty", tx_empty, 1);
        cfg_word = 0; rx_fill(8'h77); host_op(0, 0, 1, 0);
        check("R12 rx untouched", rx_empty, 0);

        // R5 byte read
        host_op(1, 0, 1, 0);
        check("R5 byte read", host_rdata, 16'h0077);
        check("R5 rx empty after", rx_empty, 1);
        // R6 word read, low lane first
        rx_fill(8'h11); rx_fill(8'h22); cfg_word = 1; cfg_swap = 0; host_op(1, 0, 1, 0);
        check("R6 word read", host_rdata, 16'h2211);
        // R7 word read, high lane first
        rx_fill(8'h11); rx_fill(8'h22); cfg_swap = 1; host_op(1, 0, 1, 0);
        check("R7 word read", host_rdata, 16'h1122);
        check("R9 no underflow yet", rx_underflow, 0);

        // R9 word read with one byte waiting
        rx_fill(8'h5C); host_op(1, 0, 1, 0);
        check("R9 short read zero", host_rdata, 0);
        check("R9 underflow set", rx_underflow, 1);
        check("R9 nothing removed", rx_empty, 0);
        cfg_word = 0; host_op(1, 0, 1, 0);
        check("R9 byte still there", host_rdata, 16'h005C);
        host_op(1, 0, 1, 0);
        check("R9 empty read zero", host_rdata, 0);
        check("R9 underflow sticky", rx_underflow, 1);

        // R10/R8 fill transmit FIFO, then overflow
        check("R8 no overflow yet", tx_overflow, 0);
        for (int i = 0; i < DEPTH; i++) host_op(1, 1, 0, 16'h0040 + 16'(i));
        check("R10 tx full", tx_full, 1);
        host_op(1, 1, 0, 16'h00EE);
        check("R8 overflow set", tx_overflow, 1);
        drain(DEPTH);
        check("R10 tx empty", tx_empty, 1);
        check("R8 dropped byte absent", txq.size(), 0);

        // R8 word write with one free slot is dropped whole
        for (int i = 0; i < DEPTH - 1; i++) host_op(1, 1, 0, 16'h0060 + 16'(i));
        cfg_word = 1; host_op(1, 1, 0, 16'hBEEF);
        check("R8 no partial word", tx_full, 0);
        cfg_word = 0; host_op(1, 1, 0, 16'h00D1);
        check("R10 full at depth", tx_full, 1);
        drain(DEPTH);
        check("R8 overflow sticky", tx_overflow, 1);

        // R10 receive FIFO full, then read as words
        for (int i = 0; i < DEPTH; i++) rx_fill(8'(8'h80 + i));
        check("R10 rx full", rx_full, 1);
        cfg_word = 1; cfg_swap = 0;
        for (int i = 0; i < DEPTH / 2; i++) begin
            host_op(1, 0, 1, 0);
            check("R6 word read from full", host_rdata,
                  {8'(8'h81 + 2*i), 8'(8'h80 + 2*i)});
        end
        check("R10 rx empty", rx_empty, 1);

        // R11 same-cycle write and read
        cfg_word = 0; rx_fill(8'h9A);
        host_op(1, 1, 1, 16'h00C3);
        check("R11 read side", host_rdata, 16'h009A);
        check("R11 rx emptied", rx_empty, 1);
        check("R11 write side", tx_empty, 0);
        drain(1);
        check("R11 queue drained", txq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule